// File: doc/BRIEF.md
# ADC Channel-Gain Table Sequencer

This block keeps an ordered list of per-conversion front-end settings. Each setting names an input channel, an input range group, a gain step, the reference choice and single-ended or differential mode. For every conversion it presents one setting to the analog front end. Software uses a small command port to empty the list, append settings one at a time, turn table mode on or off, load a single bypass setting, restart the list and freeze stepping.

With table mode on and at least one entry stored, each conversion strobe moves the read pointer one step. After the last stored entry the pointer goes back to entry 0, and a start-of-scan flag is high whenever entry 0 is presented. With table mode off, or with an empty list, the bypass setting drives every conversion. The table depth is a parameter. A full flag blocks appends once the list holds that many entries.

Top module: `cgt_sequencer`

## Requirements
- R1: After reset the list is empty, table mode is off, stepping is not frozen and the bypass setting is zero, so `entry_o` = 0, `sos_o` = 1 and `full_o` = 0.
- R2: Entry layout: bits 3:0 channel, bits 6:4 gain step, bit 7 external analog common reference, bits 9:8 range group, bit 10 differential mode. The block passes every bit through unchanged.
- R3: A command is taken when `wr_en_i` is high at a rising clock edge. `wr_cmd_i` selects it: 0 empties the list, 1 appends `wr_data_i`, 2 loads the bypass setting, 3 sets table mode to `wr_data_i[0]`, 4 sets freeze to `wr_data_i[0]`, 5 restarts at entry 0. Codes 6 and 7 do nothing.
- R4: Emptying the list sets its length to zero. Later appends store entries at positions 0, 1, 2, ... in write order.
- R5: When table mode is off or the list is empty, `entry_o` equals the bypass setting and `sos_o` = 1. Conversion strobes do not change this.
- R6: With table mode on, the list not empty and freeze off, each cycle with `conv_i` high moves the presented entry from position k to k+1. After the last stored entry it returns to position 0.
- R7: With table mode on and the list not empty, `sos_o` is 1 exactly when the entry at position 0 is presented.
- R8: The restart command, and any command that turns table mode on from off, returns the pointer to position 0 in the next cycle.
- R9: While freeze is on, conversion strobes do not move the pointer.
- R10: While table mode is on and `run_i` is high, empty and append commands are ignored. The stored list and the presented entry are unchanged.
- R11: `full_o` is 1 when the list holds DEPTH entries. Appends while full are ignored, so the wrap point stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Command valid |
| wr_cmd_i | input | 3 | Command code |
| wr_data_i | input | 11 | Command data / entry |
| run_i | input | 1 | Conversion sequence running |
| conv_i | input | 1 | Conversion strobe, one per conversion |
| entry_o | output | 11 | Setting for the current conversion |
| sos_o | output | 1 | Start-of-scan indication |
| full_o | output | 1 | List holds DEPTH entries |

## Verification
The assertions assume `conv_i` and the commands are sampled single-cycle pulses, so one strobe means one step. They also assume the list length changes only through empty and append commands. The pointer-range and wrap checks rely on the pointer never being above the stored length, which holds because every empty also resets the pointer. The stimulus uses one-cycle pulses driven one time unit after the clock edge. It sweeps every list length from 1 to the bench depth, and it issues locked writes only while table mode is on with `run_i` high.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam int ENTRY_W = 11;
  localparam int GAIN_LSB = 4;
  localparam int EXT_REF_BIT = 7;
  localparam int DIFF_BIT = 10;

  typedef enum logic [2:0] {
    CMD_CLEAR   = 3'd0,
    CMD_APPEND  = 3'd1,
    CMD_LATCH   = 3'd2,
    CMD_MODE    = 3'd3,
    CMD_FREEZE  = 3'd4,
    CMD_RESTART = 3'd5
  } cgt_cmd_e;
endpackage

// File: rtl/cgt_ctrl.sv
module cgt_ctrl
  import cgt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_cmd_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               run_i,
  input  logic               full_i,
  output logic               tbl_en_o,
  output logic               frozen_o,
  output logic               clear_o,
  output logic               append_o,
  output logic               restart_o,
  output logic [ENTRY_W-1:0] latch_o
);
  logic locked;
  logic is_clear, is_append, is_latch, is_mode, is_freeze, is_restart;

  assign locked     = tbl_en_o & run_i;
  assign is_clear   = wr_en_i && (wr_cmd_i == CMD_CLEAR);
  assign is_append  = wr_en_i && (wr_cmd_i == CMD_APPEND);
  assign is_latch   = wr_en_i && (wr_cmd_i == CMD_LATCH);
  assign is_mode    = wr_en_i && (wr_cmd_i == CMD_MODE);
  assign is_freeze  = wr_en_i && (wr_cmd_i == CMD_FREEZE);
  assign is_restart = wr_en_i && (wr_cmd_i == CMD_RESTART);

  assign clear_o   = is_clear & ~locked;
  assign append_o  = is_append & ~locked & ~full_i;
  // enabling from off also restarts the list
  assign restart_o = is_restart | (is_mode & wr_data_i[0] & ~tbl_en_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_en_o <= 1'b0;
      frozen_o <= 1'b0;
      latch_o  <= '0;
    end else begin
      if (is_mode)   tbl_en_o <= wr_data_i[0];
      if (is_freeze) frozen_o <= wr_data_i[0];
      if (is_latch)  latch_o  <= wr_data_i;
    end
  end
endmodule

// File: rtl/cgt_store.sv
module cgt_store
  import cgt_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               append_i,
  input  logic [ENTRY_W-1:0] data_i,
  input  logic [PTR_W-1:0]   rd_ptr_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               full_o
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  assign full_o    = (count_o == CNT_W'(DEPTH));
  assign rd_data_o = mem[rd_ptr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_o <= '0;
    else if (clear_i)  count_o <= '0;
    else if (append_i) count_o <= count_o + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (append_i && !clear_i) mem[count_o[PTR_W-1:0]] <= data_i;
  end

  // R11
  append_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    append_i |-> (count_o < CNT_W'(DEPTH)));
endmodule

// File: rtl/cgt_rdptr.sv
module cgt_rdptr #(
  parameter int DEPTH = 1024,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             tbl_en_i,
  input  logic             frozen_i,
  input  logic             clear_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [CNT_W-1:0] ptr_ext;
  logic             step, at_last;

  assign ptr_ext = CNT_W'(ptr_o);
  assign at_last = (ptr_ext == count_i - 1'b1);
  assign step    = conv_i & tbl_en_i & ~frozen_i & (count_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ptr_o <= '0;
    else if (clear_i || restart_i)  ptr_o <= '0;
    else if (step)                  ptr_o <= at_last ? '0 : ptr_o + 1'b1;
  end

  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_ext < count_i) || (ptr_o == '0));

  // R6
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !clear_i && !restart_i) |=>
      ((ptr_o == PTR_W'($past(ptr_o) + 1'b1)) ||
       ((ptr_o == '0) && ($past(ptr_ext) == $past(count_i) - 1'b1))));

  // R9
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_i && !clear_i && !restart_i) |=> $stable(ptr_o));
endmodule

// File: rtl/cgt_sequencer.sv
module cgt_sequencer
  import cgt_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_cmd_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               run_i,
  input  logic               conv_i,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               sos_o,
  output logic               full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic               tbl_en, frozen, do_clear, do_append, do_restart;
  logic [ENTRY_W-1:0] latch_q, rd_data;
  logic [CNT_W-1:0]   tbl_count;
  logic [PTR_W-1:0]   rd_ptr;
  logic               table_live;

  cgt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cmd_i  (wr_cmd_i),
    .wr_data_i (wr_data_i),
    .run_i     (run_i),
    .full_i    (full_o),
    .tbl_en_o  (tbl_en),
    .frozen_o  (frozen),
    .clear_o   (do_clear),
    .append_o  (do_append),
    .restart_o (do_restart),
    .latch_o   (latch_q)
  );

  cgt_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (do_clear),
    .append_i  (do_append),
    .data_i    (wr_data_i),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (rd_data),
    .count_o   (tbl_count),
    .full_o    (full_o)
  );

  cgt_rdptr #(.DEPTH(DEPTH)) u_rdptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .conv_i    (conv_i),
    .tbl_en_i  (tbl_en),
    .frozen_i  (frozen),
    .clear_i   (do_clear),
    .restart_i (do_restart),
    .count_i   (tbl_count),
    .ptr_o     (rd_ptr)
  );

  assign table_live = tbl_en & (tbl_count != '0);
  assign entry_o    = table_live ? rd_data : latch_q;
  assign sos_o      = table_live ? (rd_ptr == '0) : 1'b1;

  // R10
  locked_list_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_en && run_i) |=> $stable(tbl_count));
endmodule

// File: tb/cgt_sequencer_test.sv
module cgt_sequencer_test;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_cmd = 3'd0;
  logic [10:0] wr_data = '0;
  logic        run = 1'b0;
  logic        conv = 1'b0;
  logic [10:0] entry;
  logic        sos, full;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cgt_sequencer #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_cmd_i(wr_cmd),
    .wr_data_i(wr_data), .run_i(run), .conv_i(conv),
    .entry_o(entry), .sos_o(sos), .full_o(full)
  );

  function automatic logic [10:0] pat(input int k, input int len);
    return 11'((k * 37 + len * 113 + 3) % 2048);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] c, input logic [10:0] d);
    wr_en = 1'b1; wr_cmd = c; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse;
    conv = 1'b1;
    @(posedge clk); #1;
    conv = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [10:0] lat;
    lat = 11'd1494;  // diff=1, range=1, ext=1, gain=5, chan=6
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    check("R1 entry", entry, 0);
    check("R1 sos", sos, 1);
    check("R1 full", full, 0);

    // R3 bypass load, R2 field pass-through
    cmd(3'd2, lat);
    check("R3 latch", entry, lat);
    check("R2 gain", entry[6:4], 5);
    check("R2 extref", entry[7], 1);
    check("R2 diff", entry[10], 1);
    check("R2 chan", entry[3:0], 6);
    cmd(3'd6, 11'd0);
    cmd(3'd7, 11'd0);
    check("R3 unused codes", entry, lat);
    // R5 strobes in bypass mode
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R5 entry", entry, lat);
      check("R5 sos", sos, 1);
    end
    // R5 enabled with empty list
    cmd(3'd3, 11'd1);
    pulse();
    check("R5 empty table", entry, lat);
    cmd(3'd3, 11'd0);

    for (int len = 1; len <= DEPTH; len++) begin
      cmd(3'd0, 11'd0);
      for (int k = 0; k < len; k++) cmd(3'd1, pat(k, len));
      // R11
      check("R11 full", full, (len == DEPTH) ? 1 : 0);
      if (len == DEPTH) begin
        cmd(3'd1, 11'd7);
        check("R11 full kept", full, 1);
      end
      cmd(3'd3, 11'd1);
      // R8 R4
      check("R4 first", entry, pat(0, len));
      check("R7 sos at 0", sos, 1);
      run = 1'b1;
      for (int s = 1; s <= 3 * len; s++) begin
        pulse();
        check("R6 step", entry, pat(s % len, len));
        check("R7 sos", sos, (s % len == 0) ? 1 : 0);
      end
      // R10 locked writes
      pulse();
      cmd(3'd1, 11'd5);
      cmd(3'd0, 11'd0);
      check("R10 clear ignored", entry, pat(1 % len, len));
      for (int s = 2; s <= len + 1; s++) begin
        pulse();
        check("R10 wrap kept", entry, pat(s % len, len));
      end
      // R9 freeze
      cmd(3'd4, 11'd1);
      for (int i = 0; i < 3; i++) begin
        pulse();
        check("R9 frozen", entry, pat((len + 1) % len, len));
      end
      cmd(3'd4, 11'd0);
      // R8 restart
      cmd(3'd5, 11'd0);
      check("R8 restart", entry, pat(0, len));
      check("R8 sos", sos, 1);
      run = 1'b0;
      // R5 table disabled
      cmd(3'd3, 11'd0);
      pulse();
      check("R5 disabled", entry, lat);
      // R8 re-enable from mid-list
      cmd(3'd3, 11'd1);
      pulse();
      cmd(3'd3, 11'd0);
      cmd(3'd3, 11'd1);
      check("R8 enable restart", entry, pat(0, len));
      cmd(3'd3, 11'd0);
    end
    // R4 clear empties list
    cmd(3'd0, 11'd0);
    check("R4 cleared full", full, 0);
    cmd(3'd3, 11'd1);
    check("R4 cleared entry", entry, lat);
    finish_run();
  end
endmodule